// File: doc/BRIEF.md
# Live-Value-Table Multi-Ported Memory

This block is a word-addressed memory with several write ports and several read ports, all usable in the same clock cycle. It is built only from simple one-write/one-read storage banks. Each write port owns a private set of banks, with one copy for each read port. A write port therefore stores its data in its own banks and never touches another port's storage.

A narrow register array holds one entry per address. Each entry is a small write-port index. On every write, the entry for the written address records which write port wrote last. On every read, the entry for the read address picks the bank set that holds the live value. From outside, the banks behave as one coherent memory.

Reads have one cycle of latency. A read that lands on an address being written in the same cycle returns the old contents. The block suits register files and shared scratch storage where several agents must update and inspect the same words in parallel.

Top module: `lvt_multiport_mem`

## Requirements
- R1: A word written through any write port is returned by a read of that address one clock edge after the read is issued; rd_data for a port changes only at the edge that samples its rd_en high.
- R2: All read ports work independently and at the same time, each returning the latest written value at its own address.
- R3: Writes through different write ports to different addresses in the same cycle both take effect (for example, port 0 writing 42 to address 1 while port 1 writes 23 to address 3).
- R4: When several write ports write the same address in the same cycle, the value of the highest-numbered of those ports is what later reads return.
- R5: A read of an address that is written in the same cycle returns the value held before that write; the new value appears on the next read.
- R6: While a read port's rd_en is low, its rd_data holds its previous value, whatever its rd_addr does.
- R7: Reset (rst_n low, asynchronous) points every address back to write port 0's banks; bank contents are not cleared, so after reset each read returns the last value write port 0 stored at that address.
- R8: The most recent write to an address decides its value, even when a lower-numbered port writes after a higher-numbered one.
- R9: A write port whose wr_en is low changes nothing, whatever its address and data inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the port-index table |
| wr_en | input | WR_PORTS | Write enable, one bit per write port |
| wr_addr | input | WR_PORTS*AW | Write addresses; port p uses bits [p*AW +: AW] |
| wr_data | input | WR_PORTS*WIDTH | Write data; port p uses bits [p*WIDTH +: WIDTH] |
| rd_en | input | RD_PORTS | Read enable, one bit per read port |
| rd_addr | input | RD_PORTS*AW | Read addresses; port r uses bits [r*AW +: AW] |
| rd_data | output | RD_PORTS*WIDTH | Read data; port r uses bits [r*WIDTH +: WIDTH] |

## Verification
Every read result is due one clock edge after the read is presented. That one edge latches both the bank word and the port-index lookup. A write becomes visible to a read issued on the following edge. The bench drives each cycle's stimulus at the falling edge and computes each read port's expected word from a single-array reference before applying that cycle's writes, in ascending port order. It then compares rd_data at the next falling edge, once the registering edge has passed. The assertions follow the same timing: they relate a write seen two edges back, via $past, to the data returned after a read issued one edge back.

// File: rtl/lvt_pkg.sv
package lvt_pkg;

  // Index width that stays at least one bit for a single-entry range
  function automatic int idx_w(input int count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction

endpackage

// File: rtl/lvt_bank.sv
// One-write, one-read storage bank with a registered, read-before-write output
module lvt_bank #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 16,
  parameter int AW    = 5
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] rdata_q;

  // Storage array: written only when the owning write port is enabled
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // Output register: samples the pre-write contents on the same edge
  always_ff @(posedge clk) begin
    if (re) begin
      rdata_q <= mem[raddr];
    end
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/lvt_table.sv
// Per-address record of the last write port, plus a registered lookup per read port
module lvt_table #(
  parameter int WR_PORTS = 2,
  parameter int RD_PORTS = 4,
  parameter int DEPTH    = 32,
  parameter int AW       = 5,
  parameter int SW       = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [WR_PORTS-1:0]    wr_en,
  input  logic [WR_PORTS*AW-1:0] wr_addr,
  input  logic [RD_PORTS-1:0]    rd_en,
  input  logic [RD_PORTS*AW-1:0] rd_addr,
  output logic [RD_PORTS*SW-1:0] sel
);

  logic [SW-1:0] owner_q   [DEPTH];
  logic [SW-1:0] owner_nxt [DEPTH];
  logic          owner_ce;

  logic [SW-1:0] sel_q   [RD_PORTS];
  logic [SW-1:0] sel_nxt [RD_PORTS];

  // Next-state: ascending port order, so the highest enabled port on a
  // shared address is the one left in the entry
  always_comb begin
    owner_nxt = owner_q;
    for (int w = 0; w < WR_PORTS; w++) begin
      if (wr_en[w]) begin
        owner_nxt[wr_addr[w*AW +: AW]] = SW'(w);
      end
    end
  end

  assign owner_ce = |wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        owner_q[i] <= '0;
      end
    end else if (owner_ce) begin
      owner_q <= owner_nxt;
    end
  end

  // Lookup for every read port, taken from the pre-write table contents
  always_comb begin
    for (int r = 0; r < RD_PORTS; r++) begin
      sel_nxt[r] = rd_en[r] ? owner_q[rd_addr[r*AW +: AW]] : sel_q[r];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < RD_PORTS; r++) begin
        sel_q[r] <= '0;
      end
    end else begin
      for (int r = 0; r < RD_PORTS; r++) begin
        if (rd_en[r]) begin
          sel_q[r] <= sel_nxt[r];
        end
      end
    end
  end

  for (genvar r = 0; r < RD_PORTS; r++) begin : g_sel_out
    assign sel[r*SW +: SW] = sel_q[r];
  end

endmodule

// File: rtl/lvt_steer.sv
// Picks one write port's bank output for a single read port
module lvt_steer #(
  parameter int WR_PORTS = 2,
  parameter int WIDTH    = 16,
  parameter int SW       = 1
) (
  input  logic [WR_PORTS*WIDTH-1:0] cand,
  input  logic [SW-1:0]             sel,
  output logic [WIDTH-1:0]          dout
);

  always_comb begin
    dout = cand[0 +: WIDTH];
    for (int w = 1; w < WR_PORTS; w++) begin
      if (sel == SW'(w)) begin
        dout = cand[w*WIDTH +: WIDTH];
      end
    end
  end

endmodule

// File: rtl/lvt_multiport_mem.sv
// Multi-write, multi-read memory from 1W/1R banks steered by a port-index table
module lvt_multiport_mem #(
  parameter int WR_PORTS = 2,
  parameter int RD_PORTS = 4,
  parameter int DEPTH    = 32,
  parameter int WIDTH    = 16,
  localparam int AW      = lvt_pkg::idx_w(DEPTH),
  localparam int SW      = lvt_pkg::idx_w(WR_PORTS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [WR_PORTS-1:0]       wr_en,
  input  logic [WR_PORTS*AW-1:0]    wr_addr,
  input  logic [WR_PORTS*WIDTH-1:0] wr_data,
  input  logic [RD_PORTS-1:0]       rd_en,
  input  logic [RD_PORTS*AW-1:0]    rd_addr,
  output logic [RD_PORTS*WIDTH-1:0] rd_data
);

  localparam int SET_W = WR_PORTS * WIDTH;

  // Bank outputs grouped per read port: [r][w] at (r*WR_PORTS + w)*WIDTH
  logic [RD_PORTS*SET_W-1:0] bank_q;
  logic [RD_PORTS*SW-1:0]    sel;

  for (genvar w = 0; w < WR_PORTS; w++) begin : g_wr
    for (genvar r = 0; r < RD_PORTS; r++) begin : g_rd
      lvt_bank #(
        .DEPTH (DEPTH),
        .WIDTH (WIDTH),
        .AW    (AW)
      ) u_bank (
        .clk   (clk),
        .we    (wr_en[w]),
        .waddr (wr_addr[w*AW +: AW]),
        .wdata (wr_data[w*WIDTH +: WIDTH]),
        .re    (rd_en[r]),
        .raddr (rd_addr[r*AW +: AW]),
        .rdata (bank_q[(r*WR_PORTS + w)*WIDTH +: WIDTH])
      );
    end
  end

  lvt_table #(
    .WR_PORTS (WR_PORTS),
    .RD_PORTS (RD_PORTS),
    .DEPTH    (DEPTH),
    .AW       (AW),
    .SW       (SW)
  ) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .sel     (sel)
  );

  for (genvar r = 0; r < RD_PORTS; r++) begin : g_steer
    lvt_steer #(
      .WR_PORTS (WR_PORTS),
      .WIDTH    (WIDTH),
      .SW       (SW)
    ) u_steer (
      .cand (bank_q[r*SET_W +: SET_W]),
      .sel  (sel[r*SW +: SW]),
      .dout (rd_data[r*WIDTH +: WIDTH])
    );
  end

endmodule

// File: rtl/lvt_multiport_mem_chk.sv
module lvt_multiport_mem_chk #(
  parameter int WR_PORTS = 2,
  parameter int RD_PORTS = 4,
  parameter int DEPTH    = 32,
  parameter int WIDTH    = 16,
  localparam int AW      = lvt_pkg::idx_w(DEPTH)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [WR_PORTS-1:0]       wr_en,
  input logic [WR_PORTS*AW-1:0]    wr_addr,
  input logic [WR_PORTS*WIDTH-1:0] wr_data,
  input logic [RD_PORTS-1:0]       rd_en,
  input logic [RD_PORTS*AW-1:0]    rd_addr,
  input logic [RD_PORTS*WIDTH-1:0] rd_data
);

  localparam int LW = WR_PORTS - 1;
  localparam int LR = RD_PORTS - 1;

  // R1
  wr_then_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) == WR_PORTS'(1) && wr_en == '0 && rd_en[0] &&
     rd_addr[0 +: AW] == $past(wr_addr[0 +: AW]))
    |=> rd_data[0 +: WIDTH] == $past(wr_data[0 +: WIDTH], 2));

  // R2
  last_rd_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) == WR_PORTS'(1) && wr_en == '0 && rd_en[LR] &&
     rd_addr[LR*AW +: AW] == $past(wr_addr[0 +: AW]))
    |=> rd_data[LR*WIDTH +: WIDTH] == $past(wr_data[0 +: WIDTH], 2));

  // R4
  top_port_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en[0] && wr_en[LW] && wr_addr[0 +: AW] == wr_addr[LW*AW +: AW]) &&
     wr_en == '0 && rd_en[0] && rd_addr[0 +: AW] == $past(wr_addr[0 +: AW]))
    |=> rd_data[0 +: WIDTH] == $past(wr_data[LW*WIDTH +: WIDTH], 2));

  for (genvar r = 0; r < RD_PORTS; r++) begin : g_hold
    // R6
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en[r] |=> $stable(rd_data[r*WIDTH +: WIDTH]));
  end

endmodule

bind lvt_multiport_mem lvt_multiport_mem_chk #(
  .WR_PORTS (WR_PORTS),
  .RD_PORTS (RD_PORTS),
  .DEPTH    (DEPTH),
  .WIDTH    (WIDTH)
) u_chk (.*);

// File: tb/lvt_multiport_mem_test.sv
`timescale 1ns/1ps
module lvt_multiport_mem_test;

  localparam int M  = 2;
  localparam int N  = 4;
  localparam int D  = 16;
  localparam int W  = 16;
  localparam int AW = 4;

  logic           clk;
  logic           rst_n;
  logic [M-1:0]   wr_en;
  logic [M*AW-1:0] wr_addr;
  logic [M*W-1:0] wr_data;
  logic [N-1:0]   rd_en;
  logic [N*AW-1:0] rd_addr;
  logic [N*W-1:0] rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [31:0] rng = 32'h1234_5678;

  logic [W-1:0] ref_mem [D];
  logic [W-1:0] exp_q   [N];

  lvt_multiport_mem #(.WR_PORTS(M), .RD_PORTS(N), .DEPTH(D), .WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data));

  initial clk = 0;
  always #5 clk = ~clk;

  function automatic logic [W-1:0] val_a(input int a);
    return W'(a * 37 + 16'h0100);
  endfunction

  function automatic logic [W-1:0] val_b(input int a);
    return W'(a * 91) ^ 16'hB5C3;
  endfunction

  function automatic logic [31:0] next_rng(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic set_wr(input int p, input bit en, input int a, input logic [W-1:0] d);
    wr_en[p] = en;
    wr_addr[p*AW +: AW] = AW'(a);
    wr_data[p*W +: W] = d;
  endtask

  task automatic set_rd(input int p, input bit en, input int a);
    rd_en[p] = en;
    rd_addr[p*AW +: AW] = AW'(a);
  endtask

  // One clock: expectations from pre-write reference, writes in port order,
  // compare at the next falling edge
  task automatic step(input string tag, input bit chk);
    for (int r = 0; r < N; r++) begin
      if (rd_en[r]) exp_q[r] = ref_mem[rd_addr[r*AW +: AW]];
    end
    for (int w = 0; w < M; w++) begin
      if (wr_en[w]) ref_mem[wr_addr[w*AW +: AW]] = wr_data[w*W +: W];
    end
    @(posedge clk);
    @(negedge clk);
    if (chk) begin
      for (int r = 0; r < N; r++) begin
        checks++;
        if (rd_data[r*W +: W] !== exp_q[r]) begin
          fails++;
          $display("FAIL %s read port %0d: actual %h expected %h",
                   tag, r, rd_data[r*W +: W], exp_q[r]);
        end
      end
    end
    wr_en = '0;
  endtask

  task automatic read_sweep(input string tag);
    for (int a = 0; a < D; a++) begin
      for (int r = 0; r < N; r++) set_rd(r, 1, (a + r) % D);
      step(tag, 1);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 0; wr_en = '0; wr_addr = '0; wr_data = '0; rd_en = '0; rd_addr = '0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // Port 0 fills every word, then port 1 overwrites every word
    for (int a = 0; a < D; a++) begin set_wr(0, 1, a, val_a(a)); step("init", 0); end
    for (int a = 0; a < D; a++) begin set_wr(1, 1, a, val_b(a)); step("init", 0); end
    read_sweep("R8 R2 after overwrite");

    // R7: reset steers back to port 0 banks, which still hold val_a
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int a = 0; a < D; a++) ref_mem[a] = val_a(a);
    read_sweep("R7 after reset");

    // R3: two ports, two addresses, same cycle
    set_wr(0, 1, 1, 16'd42);
    set_wr(1, 1, 3, 16'd23);
    step("R3 write", 0);
    set_rd(0, 1, 3); set_rd(1, 1, 1); set_rd(2, 1, 3); set_rd(3, 1, 1);
    step("R3", 1);

    // R4: both ports on one address
    set_wr(0, 1, 5, 16'h1111);
    set_wr(1, 1, 5, 16'h2222);
    step("R4 write", 0);
    for (int r = 0; r < N; r++) set_rd(r, 1, 5);
    step("R4", 1);

    // R8: lower port writes after higher port
    set_wr(1, 1, 6, 16'hAAAA); step("R8 write", 0);
    set_wr(0, 1, 6, 16'h5555); step("R8 write", 0);
    for (int r = 0; r < N; r++) set_rd(r, 1, 6);
    step("R8", 1);

    // R5: read during write returns old, then R1 new value next read
    for (int r = 0; r < N; r++) set_rd(r, 1, 7);
    set_wr(1, 1, 7, 16'h7E57);
    step("R5", 1);
    step("R1", 1);

    // R6: disabled read ports hold output while addresses and data change
    for (int r = 0; r < N; r++) set_rd(r, 0, r + 9);
    set_wr(0, 1, 7, 16'h0BAD);
    step("R6", 1);
    step("R6", 1);

    // R9: disabled write ports carry address and data but change nothing
    set_wr(0, 0, 9, 16'hDEAD);
    set_wr(1, 0, 9, 16'hBEEF);
    step("R9 idle", 0);
    for (int r = 0; r < N; r++) set_rd(r, 1, 9);
    step("R9", 1);

    // Mixed traffic with conflicts, holds and read-during-write
    for (int i = 0; i < 600; i++) begin
      for (int w = 0; w < M; w++) begin
        rng = next_rng(rng);
        set_wr(w, rng[0] | rng[1], int'(rng[7:4]), rng[31:16]);
      end
      for (int r = 0; r < N; r++) begin
        rng = next_rng(rng);
        set_rd(r, rng[2] | rng[3], int'(rng[11:8]));
      end
      step("R2 mixed", 1);
    end

    summary();
  end

endmodule